// File: doc/BRIEF.md
# Flash Control Register Bank

This block holds the two byte-wide control registers of an embedded flash controller: a configuration register and a protection register. Software reaches them over a simple byte bus. Reads are combinational. Writes land on the rising clock edge when the write enable is high and the address matches one of the two offsets.

Each register bit has its own write-permission rule. The configuration register carries two interrupt enables and a key-access enable. The key-access bit accepts writes only while the security block reports that key entry is allowed. While key access is set, the bank steers flash-array writes to a key-capture strobe and marks array reads as invalid. While key access is clear, an array write starts a command sequence.

The protection register comes out of reset with every bit set. Its open/protect select and its two region-disable bits can only be cleared. Each region's size field freezes once that region's disable bit has been cleared. The bank also combines the two interrupt enables with the status flags from the command logic into a single interrupt request.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset, the configuration register (offset 0x3) reads 0x00, the protection register (offset 0x4) reads 0xFF, and every protection output is 1.
- R2: In the configuration register, bit 7 (buffer-empty interrupt enable) and bit 6 (command-complete interrupt enable) take any written value. Bits 4:0 always read 0 and ignore writes.
- R3: Configuration bit 5 (key access) takes the written value only while `keyEnable` is 1. Otherwise it keeps its value, and bits 7:6 of the same write still take effect.
- R4: `irq` is 1 exactly when (bit 7 = 1 and `bufEmptyFlag` = 1) or (bit 6 = 1 and `cmdDoneFlag` = 1).
- R5: While key access is 1, `arrayWe` raises `keyWriteStb` in the same cycle and `cmdStartStb` stays 0. `arrayRe` raises `invalidRead` in the same cycle.
- R6: While key access is 0, `arrayWe` raises `cmdStartStb` in the same cycle and `keyWriteStb` stays 0. `invalidRead` stays 0.
- R7: Protection bit 7 (open/protect select, output `protOpen`) can change from 1 to 0 but never from 0 to 1.
- R8: Protection bit 5 (high-region disable) and bit 2 (low-region disable) can only change from 1 to 0. Bit 6 is read-only and reads 1.
- R9: Protection bits 1:0 (low-region size) take the written value only if bit 2 was 1 before the write. Otherwise they are frozen.
- R10: Protection bits 4:3 (high-region size) take the written value only if bit 5 was 1 before the write. Otherwise they are frozen.
- R11: Any other address reads 0x00, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Register write enable |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data, combinational |
| bufEmptyFlag | input | 1 | Command buffer empty status flag |
| cmdDoneFlag | input | 1 | All commands complete status flag |
| keyEnable | input | 1 | Security block allows key-access writes |
| arrayWe | input | 1 | Write access to the flash array |
| arrayRe | input | 1 | Read access to the flash array |
| irq | output | 1 | Interrupt request |
| keyWriteStb | output | 1 | Array write captured as a backdoor key word |
| cmdStartStb | output | 1 | Array write starts a command sequence |
| invalidRead | output | 1 | Array read returns invalid data |
| protOpen | output | 1 | Open/protect select |
| protHiDis | output | 1 | High-region protection disable |
| protHiSize | output | 2 | High-region size |
| protLoDis | output | 1 | Low-region protection disable |
| protLoSize | output | 2 | Low-region size |

## Verification
Register writes take effect at the clock edge that samples `busWe`. Their results are therefore due on `busRdata` and the protection outputs one cycle after the write is driven. `irq`, the two array strobes, `invalidRead` and read data follow their inputs in the same cycle, with no register between them. The driver changes inputs on the falling edge and queues what it expects. The monitor compares the queue a quarter period later, which is after the falling edge and before the next rising edge. So a register result is checked only after the edge that stores it, and a combinational result is checked in the cycle that produces it.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CFG_RESET  = 8'h00;
  localparam logic [BYTE_W-1:0] PROT_RESET = 8'hFF;
  localparam int REGION_CNT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic keyAccWr;
    logic protWr;
    logic rdCfg;
    logic rdProt;
  } regStrobes_t;
endpackage

// File: rtl/flash_regs_ctrl.sv
module flash_regs_ctrl
  import flash_regs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CFG_OFFSET  = 3,
  parameter int PROT_OFFSET = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              keyEnable,
  input  logic              arrayWe,
  input  logic              arrayRe,
  input  logic              keyAccQ,
  output regStrobes_t       strobes,
  output logic              keyWriteStb,
  output logic              cmdStartStb,
  output logic              invalidRead
);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_OFFSET);
  localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(PROT_OFFSET);

  logic hitCfg;
  logic hitProt;

  always_comb begin
    hitCfg           = (busAddr == CFG_ADDR);
    hitProt          = (busAddr == PROT_ADDR);
    strobes.rdCfg    = hitCfg;
    strobes.rdProt   = hitProt;
    strobes.cfgWr    = busWe && hitCfg;
    strobes.keyAccWr = busWe && hitCfg && keyEnable;
    strobes.protWr   = busWe && hitProt;
  end

  // Route array accesses depending on key-access mode
  always_comb begin
    keyWriteStb = arrayWe && keyAccQ;
    cmdStartStb = arrayWe && !keyAccQ;
    invalidRead = arrayRe && keyAccQ;
  end
endmodule

// File: rtl/flash_regs_dp.sv
module flash_regs_dp
  import flash_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              bufEmptyFlag,
  input  logic              cmdDoneFlag,
  output logic [BYTE_W-1:0] busRdata,
  output logic              irq,
  output logic              keyAccQ,
  output logic [BYTE_W-1:0] protQ
);
  localparam int BE_BIT  = 7;
  localparam int CC_BIT  = 6;
  localparam int KEY_BIT = 5;
  localparam int OPEN_BIT = 7;
  localparam int NV_BIT   = 6;

  logic bufEmptyIeQ;
  logic cmdDoneIeQ;
  logic [BYTE_W-1:0] cfgView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufEmptyIeQ <= CFG_RESET[BE_BIT];
      cmdDoneIeQ  <= CFG_RESET[CC_BIT];
    end else if (strobes.cfgWr) begin
      bufEmptyIeQ <= busWdata[BE_BIT];
      cmdDoneIeQ  <= busWdata[CC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 keyAccQ <= CFG_RESET[KEY_BIT];
    else if (strobes.keyAccWr) keyAccQ <= busWdata[KEY_BIT];
  end

  // Open/protect select: clear-only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               protQ[OPEN_BIT] <= PROT_RESET[OPEN_BIT];
    else if (strobes.protWr) protQ[OPEN_BIT] <= protQ[OPEN_BIT] & busWdata[OPEN_BIT];
  end

  // Read-only non-volatile bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protQ[NV_BIT] <= PROT_RESET[NV_BIT];
    else       protQ[NV_BIT] <= protQ[NV_BIT];
  end

  // Each protected region: clear-only disable, size frozen once disable is cleared
  for (genvar g = 0; g < REGION_CNT; g++) begin : gRegion
    localparam int SZ_LO = 3 * g;
    localparam int DIS_B = 3 * g + 2;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        protQ[DIS_B]         <= PROT_RESET[DIS_B];
        protQ[SZ_LO+1:SZ_LO] <= PROT_RESET[SZ_LO+1:SZ_LO];
      end else if (strobes.protWr) begin
        protQ[DIS_B] <= protQ[DIS_B] & busWdata[DIS_B];
        if (protQ[DIS_B]) protQ[SZ_LO+1:SZ_LO] <= busWdata[SZ_LO+1:SZ_LO];
      end
    end
  end

  always_comb begin
    cfgView = '0;
    cfgView[BE_BIT]  = bufEmptyIeQ;
    cfgView[CC_BIT]  = cmdDoneIeQ;
    cfgView[KEY_BIT] = keyAccQ;
    if (strobes.rdCfg)       busRdata = cfgView;
    else if (strobes.rdProt) busRdata = protQ;
    else                     busRdata = '0;
    irq = (bufEmptyIeQ && bufEmptyFlag) || (cmdDoneIeQ && cmdDoneFlag);
  end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_regs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CFG_OFFSET  = 3,
  parameter int PROT_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              bufEmptyFlag,
  input  logic              cmdDoneFlag,
  input  logic              keyEnable,
  input  logic              arrayWe,
  input  logic              arrayRe,
  output logic              irq,
  output logic              keyWriteStb,
  output logic              cmdStartStb,
  output logic              invalidRead,
  output logic              protOpen,
  output logic              protHiDis,
  output logic [1:0]        protHiSize,
  output logic              protLoDis,
  output logic [1:0]        protLoSize
);
  regStrobes_t strobes;
  logic        keyAccQ;
  logic [7:0]  protQ;

  flash_regs_ctrl #(
    .ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET), .PROT_OFFSET(PROT_OFFSET)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .keyEnable(keyEnable),
    .arrayWe(arrayWe), .arrayRe(arrayRe), .keyAccQ(keyAccQ),
    .strobes(strobes), .keyWriteStb(keyWriteStb),
    .cmdStartStb(cmdStartStb), .invalidRead(invalidRead)
  );

  flash_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .bufEmptyFlag(bufEmptyFlag), .cmdDoneFlag(cmdDoneFlag),
    .busRdata(busRdata), .irq(irq), .keyAccQ(keyAccQ), .protQ(protQ)
  );

  assign protOpen   = protQ[7];
  assign protHiDis  = protQ[5];
  assign protHiSize = protQ[4:3];
  assign protLoDis  = protQ[2];
  assign protLoSize = protQ[1:0];
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk #(
  parameter int ADDR_W      = 8,
  parameter int CFG_OFFSET  = 3,
  parameter int PROT_OFFSET = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              bufEmptyFlag,
  input logic              cmdDoneFlag,
  input logic              keyEnable,
  input logic              arrayWe,
  input logic              irq,
  input logic              keyWriteStb,
  input logic              cmdStartStb,
  input logic              keyAccQ,
  input logic              protOpen,
  input logic              protHiDis,
  input logic [1:0]        protHiSize,
  input logic              protLoDis,
  input logic [1:0]        protLoSize
);
  a_r7_open_no_set: assert property (@(posedge clk) disable iff (!rstN)
    !protOpen |=> !protOpen);
  a_r8_lodis_no_set: assert property (@(posedge clk) disable iff (!rstN)
    !protLoDis |=> !protLoDis);
  a_r8_hidis_no_set: assert property (@(posedge clk) disable iff (!rstN)
    !protHiDis |=> !protHiDis);
  a_r9_losize_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !protLoDis |=> $stable(protLoSize));
  a_r10_hisize_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !protHiDis |=> $stable(protHiSize));
  a_r3_key_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!keyEnable && busWe && busAddr == ADDR_W'(CFG_OFFSET)) |=> $stable(keyAccQ));
  a_r4_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!bufEmptyFlag && !cmdDoneFlag) |-> !irq);
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({keyWriteStb, cmdStartStb}) == (arrayWe ? 1 : 0));
  a_r11_other_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != ADDR_W'(CFG_OFFSET) && busAddr != ADDR_W'(PROT_OFFSET))
      |=> $stable(keyAccQ));
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET), .PROT_OFFSET(PROT_OFFSET)
) u_chk (.*);

// File: tb/flash_ctl_regs_tb.sv
module flash_ctl_regs_tb;
  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] busAddr = 0;
  logic       busWe = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic       bufEmptyFlag = 0, cmdDoneFlag = 0, keyEnable = 0;
  logic       arrayWe = 0, arrayRe = 0;
  logic       irq, keyWriteStb, cmdStartStb, invalidRead;
  logic       protOpen, protHiDis, protLoDis;
  logic [1:0] protHiSize, protLoSize;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef enum int {S_RDATA, S_IRQ, S_KEYSTB, S_CMDSTB, S_INVRD, S_PROT} sel_e;
  typedef struct {
    sel_e       sel;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  flash_ctl_regs u_dut (.*);

  function automatic logic [7:0] actual(sel_e s);
    case (s)
      S_RDATA:  return busRdata;
      S_IRQ:    return {7'd0, irq};
      S_KEYSTB: return {7'd0, keyWriteStb};
      S_CMDSTB: return {7'd0, cmdStartStb};
      S_INVRD:  return {7'd0, invalidRead};
      default:  return {protOpen, 1'b1, protHiDis, protHiSize, protLoDis, protLoSize};
    endcase
  endfunction

  // Monitor: compares queued expectations a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (actual(it.sel) !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h",
                   it.req, it.sel, actual(it.sel), it.exp);
        end
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [7:0] e, input string r);
    busAddr = a;
    sb.push_back('{S_RDATA, e, r});
    @(negedge clk);
  endtask

  task automatic expectSig(input sel_e s, input logic v, input string r);
    sb.push_back('{s, {7'd0, v}, r});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    expectRead(8'h03, 8'h00, "R1 cfg reset");
    sb.push_back('{S_PROT, 8'hFF, "R1 prot outputs"});
    expectRead(8'h04, 8'hFF, "R1 prot reset");
    // R2/R3 enables written, key bit blocked
    regWrite(8'h03, 8'hFF);
    expectRead(8'h03, 8'hC0, "R2 R3 cfg write with key disabled");
    // R4 irq
    bufEmptyFlag = 1; expectSig(S_IRQ, 1, "R4 buffer empty irq"); @(negedge clk);
    bufEmptyFlag = 0; cmdDoneFlag = 1; expectSig(S_IRQ, 1, "R4 cmd done irq"); @(negedge clk);
    regWrite(8'h03, 8'h40);
    expectRead(8'h03, 8'h40, "R2 clear bit7");
    bufEmptyFlag = 1; cmdDoneFlag = 0; expectSig(S_IRQ, 0, "R4 masked buffer empty"); @(negedge clk);
    bufEmptyFlag = 0;
    // R6 command mode
    arrayWe = 1;
    expectSig(S_CMDSTB, 1, "R6 cmd start"); expectSig(S_KEYSTB, 0, "R6 no key strobe");
    @(negedge clk);
    arrayWe = 0; arrayRe = 1; expectSig(S_INVRD, 0, "R6 read valid"); @(negedge clk);
    arrayRe = 0;
    // R3 key access with enable
    keyEnable = 1;
    regWrite(8'h03, 8'h20);
    expectRead(8'h03, 8'h20, "R3 key set when enabled");
    keyEnable = 0;
    regWrite(8'h03, 8'h1F);
    expectRead(8'h03, 8'h20, "R3 key held, low bits ignored");
    // R5 key mode
    arrayWe = 1;
    expectSig(S_KEYSTB, 1, "R5 key strobe"); expectSig(S_CMDSTB, 0, "R5 no cmd start");
    @(negedge clk);
    arrayWe = 0; arrayRe = 1; expectSig(S_INVRD, 1, "R5 invalid read"); @(negedge clk);
    arrayRe = 0;
    // R11 unmapped address
    regWrite(8'h05, 8'h00);
    expectRead(8'h05, 8'h00, "R11 unmapped read");
    expectRead(8'h03, 8'h20, "R11 cfg untouched");
    expectRead(8'h04, 8'hFF, "R11 prot untouched");
    // R7 open bit clear-only
    regWrite(8'h04, 8'h7F);
    expectRead(8'h04, 8'h7F, "R7 open cleared");
    regWrite(8'h04, 8'hFF);
    expectRead(8'h04, 8'h7F, "R7 open not set");
    // R9 low size
    regWrite(8'h04, 8'h7C);
    expectRead(8'h04, 8'h7C, "R9 low size writable");
    regWrite(8'h04, 8'h79);
    expectRead(8'h04, 8'h79, "R9 size taken with disable clear");
    regWrite(8'h04, 8'h7E);
    expectRead(8'h04, 8'h79, "R8 R9 low frozen");
    // R10 high size
    regWrite(8'h04, 8'h59);
    expectRead(8'h04, 8'h59, "R10 high size taken");
    regWrite(8'h04, 8'h67);
    expectRead(8'h04, 8'h59, "R8 R10 high frozen");
    regWrite(8'h04, 8'h00);
    sb.push_back('{S_PROT, 8'h59, "R8 bit6 read-only outputs"});
    expectRead(8'h04, 8'h59, "R8 bit6 read-only");
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule